// File: doc/BRIEF.md
# Dual Double-Buffered Converter Register Bank

This block is the digital loading front end for a pair of 12-bit converter channels. Each channel has two ranks of storage. The first rank is an input rank that holds the next code. It is filled one part at a time from an 8-bit parallel bus: a full low byte, and a 4-bit upper field. The second rank is an output rank that drives the converter. It copies the input rank on command, so both channels can change their codes on the same clock edge.

All control inputs are active-low levels, sampled on the rising edge of the system clock. Two address bits choose the channel and which part of the word is written. A write strobe must be low for anything to move. A select input enables loading of the input rank, and a transfer input copies the input rank into the output rank. When select and transfer are both low, the output rank follows the write in the same cycle. A clear input, and the synchronous active-high reset, zero both ranks and take precedence over every other input.

The two outputs are the output-rank codes of channel A and channel B. Each is registered, so it changes one clock edge after the qualifying inputs are sampled.

Top module: `dual_dac_regs`

## Requirements
- R1: While `rst` is high or `zero_n` is low at a rising edge, both ranks of both channels become zero at that edge, whatever the other inputs are.
- R2: When `strobe_n` is low, `sel_n` is low and `xfer_n` is high, the input-rank part chosen by `adr` is written at that edge. `adr` = 00 writes channel A bits 7:0, 01 writes channel A bits 11:8, 10 writes channel B bits 7:0 and 11 writes channel B bits 11:8. Neither output changes.
- R3: When `strobe_n` is high, or when `sel_n` and `xfer_n` are both high, no register in either rank changes.
- R4: An upper-part write takes only `bus_data[3:0]` as bits 11:8 of the channel code. `bus_data[7:4]` has no effect.
- R5: When `strobe_n` and `xfer_n` are low and `sel_n` is high, both outputs take their channel's input-rank code at the same edge. No input-rank register changes.
- R6: When `strobe_n`, `sel_n` and `xfer_n` are all low, the addressed part is written into the input rank. At the same edge both outputs take their channel's updated input-rank code, so the addressed channel shows the new part merged with its other, unchanged bits.
- R7: Each output changes only at the clock edge that follows the sampled inputs. After full-scale bytes are loaded and transferred, both outputs read 0xFFF. After a clear, both read 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears both ranks |
| zero_n | input | 1 | Synchronous clear of both ranks, active low |
| sel_n | input | 1 | Enables writing of the input rank, active low |
| strobe_n | input | 1 | Write strobe, active low |
| xfer_n | input | 1 | Transfer of the input rank to the output rank, active low |
| adr | input | 2 | Bit 1 picks the channel (0 = A, 1 = B), bit 0 picks the part (0 = low byte, 1 = upper field) |
| bus_data | input | 8 | Parallel data bus |
| out_a | output | 12 | Output-rank code of channel A |
| out_b | output | 12 | Output-rank code of channel B |

## Verification
The directed part of the test targets one address at a time. It loads each channel with parts whose values differ, so that a swapped channel or a swapped part shows as a wrong code after the next transfer. It writes upper fields with nonzero bus bits 7:4, which exposes any leak of those bits into the code. It repeats a write with the strobe high, and again with both select and transfer high, and then transfers. This shows that the idle combinations touch neither rank. A transparent write to one channel, while the other channel holds a different pending value, tells the merge of the written part apart from a plain copy of the bus. The last phase draws control levels and data from a pseudo-random sequence that includes occasional clears, and checks every cycle against a behavioural model.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int BUS_W   = 8;
    localparam int HI_W    = 4;
    localparam int WORD_W  = BUS_W + HI_W;
    localparam int NUM_CH  = 2;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ADDR_W  = CH_W + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [BUS_W-1:0] lo;
    } inreg_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_UPDATE,
        OP_FLOW
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [CH_W-1:0] chan;
        logic            upper;
    } cmd_t;

    // Priority: reset/clear, then strobe gating, then select/transfer pair.
    function automatic op_e classify(input logic rst, input logic zero_n,
                                     input logic sel_n, input logic strobe_n,
                                     input logic xfer_n);
        if (rst || !zero_n) return OP_CLEAR;
        if (strobe_n)       return OP_HOLD;
        case ({sel_n, xfer_n})
            2'b01:   return OP_LOAD;
            2'b10:   return OP_UPDATE;
            2'b00:   return OP_FLOW;
            default: return OP_HOLD;
        endcase
    endfunction

    function automatic inreg_t merge_part(input inreg_t cur, input logic upper,
                                          input logic [BUS_W-1:0] d);
        inreg_t r;
        r = cur;
        if (upper) r.hi = d[HI_W-1:0];
        else       r.lo = d;
        return r;
    endfunction

    function automatic word_t as_word(input inreg_t r);
        return {r.hi, r.lo};
    endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
(
    input  logic              rst,
    input  logic              zero_n,
    input  logic              sel_n,
    input  logic              strobe_n,
    input  logic              xfer_n,
    input  logic [ADDR_W-1:0] adr,
    output cmd_t              cmd
);
    always_comb begin
        cmd.op    = classify(rst, zero_n, sel_n, strobe_n, xfer_n);
        cmd.upper = adr[0];
        cmd.chan  = adr[ADDR_W-1:1];
    end
endmodule

// File: rtl/dacreg_channel.sv
module dacreg_channel
    import dacreg_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic             clk,
    input  cmd_t             cmd,
    input  logic [BUS_W-1:0] bus_data,
    output word_t            dac_code
);
    localparam logic [CH_W-1:0] MY_CHAN = CH_IDX[CH_W-1:0];

    inreg_t in_q;
    inreg_t in_nx;
    word_t  dac_q;
    logic   hit;
    logic   copy;

    always_comb begin
        hit   = ((cmd.op == OP_LOAD) || (cmd.op == OP_FLOW)) && (cmd.chan == MY_CHAN);
        copy  = (cmd.op == OP_UPDATE) || (cmd.op == OP_FLOW);
        in_nx = hit ? merge_part(in_q, cmd.upper, bus_data) : in_q;
    end

    always_ff @(posedge clk) begin
        if (cmd.op == OP_CLEAR) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            in_q <= in_nx;
            if (copy) dac_q <= as_word(in_nx);
        end
    end

    assign dac_code = dac_q;
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
    import dacreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                zero_n,
    input  logic                sel_n,
    input  logic                strobe_n,
    input  logic                xfer_n,
    input  logic [ADDR_W-1:0]   adr,
    input  logic [BUS_W-1:0]    bus_data,
    output logic [WORD_W-1:0]   out_a,
    output logic [WORD_W-1:0]   out_b
);
    cmd_t  cmd;
    word_t codes [NUM_CH];

    dacreg_decode u_dec (
        .rst      (rst),
        .zero_n   (zero_n),
        .sel_n    (sel_n),
        .strobe_n (strobe_n),
        .xfer_n   (xfer_n),
        .adr      (adr),
        .cmd      (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dacreg_channel #(.CH_IDX(c)) u_ch (
            .clk      (clk),
            .cmd      (cmd),
            .bus_data (bus_data),
            .dac_code (codes[c])
        );
    end

    assign out_a = codes[0];
    assign out_b = codes[1];
endmodule

// File: rtl/dacreg_checker.sv
module dacreg_checker
    import dacreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              zero_n,
    input logic              sel_n,
    input logic              strobe_n,
    input logic              xfer_n,
    input logic [ADDR_W-1:0] adr,
    input logic [BUS_W-1:0]  bus_data,
    input logic [WORD_W-1:0] out_a,
    input logic [WORD_W-1:0] out_b
);
    logic live, upd_now, flow_now, load_now, idle_now;
    assign live     = !rst && zero_n;
    assign upd_now  = live && !strobe_n && sel_n && !xfer_n;
    assign flow_now = live && !strobe_n && !sel_n && !xfer_n;
    assign load_now = live && !strobe_n && !sel_n && xfer_n;
    assign idle_now = live && (strobe_n || (sel_n && xfer_n));

    assert_clear_zeroes_R1: assert property (@(posedge clk)
        !zero_n |=> (out_a == '0) && (out_b == '0));

    assert_load_keeps_out_R2: assert property (@(posedge clk) disable iff (rst)
        load_now |=> $stable(out_a) && $stable(out_b));

    assert_idle_keeps_out_R3: assert property (@(posedge clk) disable iff (rst)
        idle_now |=> $stable(out_a) && $stable(out_b));

    assert_update_twice_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_now && $past(upd_now)) |=> $stable(out_a) && $stable(out_b));

    assert_flow_low_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (flow_now && adr == 2'b00) |=> out_a[BUS_W-1:0] == $past(bus_data));

    assert_flow_upper_field_R4: assert property (@(posedge clk) disable iff (rst)
        (flow_now && adr == 2'b11) |=> out_b[WORD_W-1:BUS_W] == $past(bus_data[HI_W-1:0]));
endmodule

bind dual_dac_regs dacreg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .zero_n   (zero_n),
    .sel_n    (sel_n),
    .strobe_n (strobe_n),
    .xfer_n   (xfer_n),
    .adr      (adr),
    .bus_data (bus_data),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, zero_n, sel_n, strobe_n, xfer_n;
    logic [1:0]  adr;
    logic [7:0]  bus_data;
    logic [11:0] out_a, out_b;

    int total = 0;
    int bad   = 0;
    int m_in  [2];
    int m_dac [2];

    dual_dac_regs uut (
        .clk(clk), .rst(rst), .zero_n(zero_n), .sel_n(sel_n),
        .strobe_n(strobe_n), .xfer_n(xfer_n), .adr(adr),
        .bus_data(bus_data), .out_a(out_a), .out_b(out_b)
    );

    // Behavioural reference: applied once per rising edge.
    task automatic model_edge();
        int ch;
        if (rst || !zero_n) begin
            m_in  = '{0, 0};
            m_dac = '{0, 0};
        end else if (!strobe_n) begin
            if (!sel_n) begin
                ch = adr[1];
                if (adr[0]) m_in[ch] = (m_in[ch] & 'h0FF) | ((bus_data & 'hF) << 8);
                else        m_in[ch] = (m_in[ch] & 'hF00) | bus_data;
            end
            if (!xfer_n) begin
                m_dac[0] = m_in[0];
                m_dac[1] = m_in[1];
            end
        end
    endtask

    task automatic step(input string req, input bit r, input bit z, input bit s,
                        input bit w, input bit x, input logic [1:0] a,
                        input logic [7:0] d);
        rst = r; zero_n = z; sel_n = s; strobe_n = w; xfer_n = x;
        adr = a; bus_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        total++;
        if (out_a !== 12'(m_dac[0]) || out_b !== 12'(m_dac[1])) begin
            bad++;
            $display("FAIL %s: actual a=%03h b=%03h expected a=%03h b=%03h",
                     req, out_a, out_b, m_dac[0], m_dac[1]);
        end
    endtask

    task automatic expect_codes(input string req, input int ea, input int eb);
        total++;
        if (out_a !== 12'(ea) || out_b !== 12'(eb)) begin
            bad++;
            $display("FAIL %s: actual a=%03h b=%03h expected a=%03h b=%03h",
                     req, out_a, out_b, ea, eb);
        end
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        m_in = '{0, 0}; m_dac = '{0, 0};
        // R1 reset state
        step("R1", 1, 1, 0, 0, 0, 2'b00, 8'hAA);
        step("R1", 1, 1, 0, 0, 0, 2'b01, 8'h55);
        expect_codes("R1", 0, 0);
        step("R3", 0, 1, 1, 1, 1, 2'b00, 8'h00);
        // R2 loads, outputs held
        step("R2", 0, 1, 0, 0, 1, 2'b00, 8'h34);
        step("R4", 0, 1, 0, 0, 1, 2'b01, 8'hF5);
        step("R2", 0, 1, 0, 0, 1, 2'b10, 8'hCD);
        step("R4", 0, 1, 0, 0, 1, 2'b11, 8'h9A);
        expect_codes("R2", 0, 0);
        // R5 simultaneous update
        step("R5", 0, 1, 1, 0, 0, 2'b00, 8'h00);
        expect_codes("R5", 'h534, 'hACD);
        // R3 idle combinations then transfer
        step("R3", 0, 1, 0, 1, 0, 2'b00, 8'hFF);
        step("R3", 0, 1, 1, 0, 1, 2'b10, 8'hEE);
        step("R5", 0, 1, 1, 0, 0, 2'b00, 8'h00);
        expect_codes("R3", 'h534, 'hACD);
        // R6 transparent with other channel pending
        step("R2", 0, 1, 0, 0, 1, 2'b00, 8'h11);
        step("R6", 0, 1, 0, 0, 0, 2'b11, 8'hE7);
        expect_codes("R6", 'h511, 'h7CD);
        // R7 full scale then clear with other inputs active
        step("R7", 0, 1, 0, 0, 1, 2'b00, 8'hFF);
        step("R7", 0, 1, 0, 0, 1, 2'b01, 8'hFF);
        step("R7", 0, 1, 0, 0, 1, 2'b10, 8'hFF);
        step("R7", 0, 1, 0, 0, 1, 2'b11, 8'hFF);
        step("R7", 0, 1, 1, 0, 0, 2'b00, 8'h00);
        expect_codes("R7", 'hFFF, 'hFFF);
        step("R1", 0, 0, 0, 0, 0, 2'b01, 8'hFF);
        expect_codes("R7", 0, 0);
        step("R1", 0, 1, 1, 0, 0, 2'b00, 8'h00);
        expect_codes("R1", 0, 0);
        // Mixed pseudo-random patterns against the model
        seed = 32'h1357;
        for (int i = 0; i < 400; i++) begin
            seed = seed * 1103515245 + 12345;
            step("R6", 0, ((seed >>> 20) & 31) != 0, seed[3], seed[5] & seed[9],
                 seed[7], seed[12:11], seed[23:16]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule